// File: doc/BRIEF.md
# Template Instantiation Reduction Core

This block is the evaluation engine of a lazy functional processor. It keeps three separate on-chip memories (a reduction stack, a code store and a heap) that can all be accessed in one clock cycle. Each step it looks at the word on top of the stack and acts on its tag. A function word causes its code template to be copied into the heap. During the copy, internal pointers are moved to heap addresses and argument slots are filled with values taken from the stack. An application word unpacks a heap segment onto the stack. An integer word swaps the two top stack entries.

Software first loads templates through a valid/ready preload port. The preload port applies back-pressure for the whole of a reduction run: ready is low while the core is busy. A producer may hold valid and its data steady, and the word is written on the first rising edge where valid and ready are both high. A start pulse seeds the stack with one word and begins reduction. The run ends in one of three ways:
- `done` when a single integer remains on the stack;
- `fault` on a stack problem;
- `heap_ovf` when the heap is exhausted.

A debug read port shows any stack entry and the current depth.

Every word is 18 bits. Bits [17:16] hold the tag: 00 integer, 01 argument, 10 application, 11 function. Bits [15:8] are field `hi` and bits [7:0] are field `lo`.

Top module: `tir_core`

## Requirements
- R1: A code word is written at `code_wr_addr` on a rising edge where `code_wr_valid` and `code_wr_ready` are both high. `code_wr_ready` is high exactly when `busy` is low.
- R2: A `start` pulse while not busy has the following effects: it clears `fault` and `heap_ovf`, resets the heap free pointer to 0, sets the stack depth to 1 with `start_word` at index 0, and raises `busy` on the next cycle. A `start` pulse while busy has no effect on the result.
- R3: With an integer on top and depth of at least 2, the two top stack entries are exchanged and the depth is unchanged.
- R4: With an application word (hi = heap address A, lo = length L) on top, that word is popped. Then heap[A+L-1] down to heap[A] are pushed, one per cycle, so heap[A] ends on top.
- R5: A function word (hi = template address P, lo = arity N) reads a header at code[P], in which hi = total length T and lo = root length S. It then copies code[P+1 .. P+T] into the heap at the free pointer, and the free pointer advances by T.
- R6: While copying, a template application word with hi = offset becomes hi = (base + offset) mod 256, where base is the free pointer value at the start of the copy. Its lo field is kept. Integer and function template words are copied unchanged.
- R7: While copying, a template argument word with lo = i (i < N) is replaced by argument i. Argument 0 is the entry directly below the function word, and argument i is i+1 entries below it. An argument word with i >= N raises `fault` and halts the core.
- R8: After the copy, the function word and its N arguments are removed from the stack and the application word (hi = base, lo = S) is pushed in their place, so the depth drops by N.
- R9: When an integer is on top and the depth is 1, `busy` falls and `done` rises. `done` stays high until the next start.
- R10: Any of the following raises a sticky `fault` and halts the core with the stack contents unchanged:
  - dispatch with an empty stack;
  - a function word with fewer than N entries below it;
  - an application word whose unwinding would exceed `STK_DEPTH`;
  - an argument word on top of the stack.
- R11: When T added to the free pointer exceeds `HEAP_DEPTH`, the core raises a sticky `heap_ovf` and halts before writing any heap word. The stack is left unchanged.
- R12: `dbg_data` always shows the stack entry at `dbg_addr`, where index 0 is the bottom of the stack. `stack_depth` shows the current number of entries.
- R13: Code is read `FETCH_W` words per access and rewritten one word per cycle. Making a template longer by k words adds k copy cycles plus the extra fetch cycles, one per `FETCH_W` words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | begin a reduction run |
| start_word | input | 18 | initial stack word |
| busy | output | 1 | reduction in progress |
| done | output | 1 | run finished with one integer left |
| fault | output | 1 | sticky stack or argument error |
| heap_ovf | output | 1 | sticky heap exhaustion |
| code_wr_valid | input | 1 | preload word valid |
| code_wr_ready | output | 1 | preload word accepted |
| code_wr_addr | input | 8 | preload address |
| code_wr_data | input | 18 | preload data |
| dbg_addr | input | 5 | stack index to observe |
| dbg_data | output | 18 | stack entry at dbg_addr |
| stack_depth | output | 6 | current stack depth |

## Verification
Faults in internal state show up at the ports as follows:
- A wrong free pointer surfaces as wrong relocated addresses in application words once the new segment is unwound, which is a few cycles after the copy ends.
- A wrong argument index or a stale fetch buffer shows as wrong words on the stack at the next halt.
- A stack pointer error shows on `stack_depth` in the very next cycle, and usually as a spurious `fault` soon after.
- Timing errors in the fetch-and-copy loop show up only as changed run lengths. The bench therefore compares the lengths of two runs instead of relying on absolute cycle counts.

// File: rtl/tir_pkg.sv
package tir_pkg;
  localparam int WORD_W = 18;

  typedef enum logic [1:0] {
    TAG_INT = 2'b00,
    TAG_ARG = 2'b01,
    TAG_APP = 2'b10,
    TAG_FUN = 2'b11
  } tag_e;

  typedef struct packed {
    tag_e       tag;
    logic [7:0] hi;
    logic [7:0] lo;
  } word_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DISP, S_FETCH, S_COPY, S_UNWIND, S_DONE, S_HALT
  } state_e;
endpackage

// File: rtl/tir_code_mem.sv
module tir_code_mem import tir_pkg::*; #(
  parameter int DEPTH   = 256,
  parameter int FETCH_W = 2,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  word_t                  wr_data,
  input  logic [AW-1:0]          rd_addr,
  output word_t [FETCH_W-1:0]    rd_row
);
  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // wide read: FETCH_W consecutive words, address wraps
  for (genvar g = 0; g < FETCH_W; g++) begin : g_rd
    assign rd_row[g] = mem[rd_addr + AW'(g)];
  end
endmodule

// File: rtl/tir_heap_mem.sv
module tir_heap_mem import tir_pkg::*; #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  word_t         wr_data,
  input  logic [AW-1:0] rd_addr,
  output word_t         rd_data
);
  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tir_stack_mem.sv
module tir_stack_mem import tir_pkg::*; #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wa_en,
  input  logic [AW-1:0] wa_addr,
  input  word_t         wa_data,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  input  word_t         wb_data,
  input  logic [AW-1:0] ra_addr,
  output word_t         ra_data,
  input  logic [AW-1:0] rb_addr,
  output word_t         rb_data,
  input  logic [AW-1:0] rc_addr,
  output word_t         rc_data
);
  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wa_en) mem[wa_addr] <= wa_data;
    if (wb_en) mem[wb_addr] <= wb_data;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
  assign rc_data = mem[rc_addr];
endmodule

// File: rtl/tir_rewriter.sv
module tir_rewriter import tir_pkg::*; (
  input  word_t       tmpl,
  input  logic [7:0]  base,
  input  logic [7:0]  arity,
  input  word_t       arg_val,
  output word_t       out,
  output logic [7:0]  arg_idx,
  output logic        bad_arg
);
  always_comb begin
    out     = tmpl;
    arg_idx = tmpl.lo;
    bad_arg = 1'b0;
    unique case (tmpl.tag)
      TAG_APP: out.hi = base + tmpl.hi;
      TAG_ARG: begin
        out     = arg_val;
        bad_arg = (tmpl.lo >= arity);
      end
      default: out = tmpl;
    endcase
  end
endmodule

// File: rtl/tir_core.sv
module tir_core import tir_pkg::*; #(
  parameter int STK_DEPTH  = 32,
  parameter int HEAP_DEPTH = 256,
  parameter int CODE_DEPTH = 256,
  parameter int FETCH_W    = 2,
  localparam int SAW = $clog2(STK_DEPTH),
  localparam int SPW = $clog2(STK_DEPTH + 1),
  localparam int CAW = $clog2(CODE_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] start_word,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              heap_ovf,
  input  logic              code_wr_valid,
  output logic              code_wr_ready,
  input  logic [CAW-1:0]    code_wr_addr,
  input  logic [WORD_W-1:0] code_wr_data,
  input  logic [SAW-1:0]    dbg_addr,
  output logic [WORD_W-1:0] dbg_data,
  output logic [SPW-1:0]    stack_depth
);
  localparam int HAW = $clog2(HEAP_DEPTH);
  localparam int HPW = $clog2(HEAP_DEPTH + 1);
  localparam int BIW = (FETCH_W > 1) ? $clog2(FETCH_W) : 1;
  localparam int XW  = 17;
  localparam logic [SPW-1:0] SP1 = SPW'(1);
  localparam logic [SPW-1:0] SP2 = SPW'(2);

  state_e               state;
  logic [SPW-1:0]       sp, dst, argtop;
  logic [HPW-1:0]       hp;
  logic [7:0]           base, arity, root, rem, uptr;
  logic [CAW-1:0]       cptr;
  word_t [FETCH_W-1:0]  fbuf;
  logic [BIW-1:0]       bidx;
  logic                 fault_q, ovf_q;

  // memory interface nets
  logic                 s_wa_en, s_wb_en;
  logic [SAW-1:0]       s_wa_addr, s_wb_addr, s_ra_addr, s_rb_addr;
  word_t                s_wa_data, s_wb_data, s_ra_data, s_rb_data, s_rc_data;
  logic                 h_wr_en;
  word_t                h_rd_data;
  logic [CAW-1:0]       c_rd_addr;
  word_t [FETCH_W-1:0]  c_row;
  word_t                rw_out;
  logic [7:0]           rw_idx;
  logic                 rw_bad;

  word_t top_w, sec_w, hdr_w;
  assign top_w = s_ra_data;
  assign sec_w = s_rb_data;
  assign hdr_w = c_row[0];

  // dispatch decode
  logic empty, app_ovf, fun_under, heap_over;
  always_comb begin
    empty     = (sp == '0);
    app_ovf   = (XW'(sp) - XW'(1) + XW'(top_w.lo)) > XW'(STK_DEPTH);
    fun_under = XW'(sp) < (XW'(top_w.lo) + XW'(1));
    heap_over = (XW'(hp) + XW'(hdr_w.hi)) > XW'(HEAP_DEPTH);
  end

  assign busy          = (state == S_DISP) || (state == S_FETCH) ||
                         (state == S_COPY) || (state == S_UNWIND);
  assign done          = (state == S_DONE);
  assign fault         = fault_q;
  assign heap_ovf      = ovf_q;
  assign code_wr_ready = !busy;
  assign stack_depth   = sp;
  assign dbg_data      = s_rc_data;

  // read address selection
  assign s_ra_addr = (state == S_COPY) ? SAW'(argtop - SPW'(rw_idx)) : SAW'(sp - SP1);
  assign s_rb_addr = SAW'(sp - SP2);
  assign c_rd_addr = (state == S_DISP) ? CAW'(top_w.hi) : cptr;

  // memory write control
  always_comb begin
    s_wa_en   = 1'b0;
    s_wa_addr = '0;
    s_wa_data = '0;
    s_wb_en   = 1'b0;
    s_wb_addr = '0;
    s_wb_data = '0;
    h_wr_en   = 1'b0;
    unique case (state)
      S_IDLE, S_DONE, S_HALT: begin
        if (start) begin
          s_wa_en   = 1'b1;
          s_wa_data = word_t'(start_word);
        end
      end
      S_DISP: begin
        if (!empty && top_w.tag == TAG_INT && sp > SP1) begin
          s_wa_en   = 1'b1;
          s_wa_addr = SAW'(sp - SP1);
          s_wa_data = sec_w;
          s_wb_en   = 1'b1;
          s_wb_addr = SAW'(sp - SP2);
          s_wb_data = top_w;
        end else if (!empty && top_w.tag == TAG_FUN && !fun_under &&
                     !heap_over && hdr_w.hi == 8'd0) begin
          s_wa_en   = 1'b1;
          s_wa_addr = SAW'(sp - SP1 - SPW'(top_w.lo));
          s_wa_data = '{tag: TAG_APP, hi: 8'(hp), lo: hdr_w.lo};
        end
      end
      S_COPY: begin
        if (!rw_bad) begin
          h_wr_en = 1'b1;
          if (rem == 8'd1) begin
            s_wa_en   = 1'b1;
            s_wa_addr = SAW'(dst);
            s_wa_data = '{tag: TAG_APP, hi: base, lo: root};
          end
        end
      end
      S_UNWIND: begin
        s_wa_en   = 1'b1;
        s_wa_addr = SAW'(sp);
        s_wa_data = h_rd_data;
      end
      default: ;
    endcase
  end

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      sp      <= '0;
      dst     <= '0;
      argtop  <= '0;
      hp      <= '0;
      base    <= '0;
      arity   <= '0;
      root    <= '0;
      rem     <= '0;
      uptr    <= '0;
      cptr    <= '0;
      fbuf    <= '0;
      bidx    <= '0;
      fault_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE, S_DONE, S_HALT: begin
          if (start) begin
            state   <= S_DISP;
            sp      <= SP1;
            hp      <= '0;
            fault_q <= 1'b0;
            ovf_q   <= 1'b0;
          end
        end
        S_DISP: begin
          if (empty) begin
            fault_q <= 1'b1;
            state   <= S_HALT;
          end else begin
            unique case (top_w.tag)
              TAG_INT: if (sp == SP1) state <= S_DONE;
              TAG_ARG: begin
                fault_q <= 1'b1;
                state   <= S_HALT;
              end
              TAG_APP: begin
                if (app_ovf) begin
                  fault_q <= 1'b1;
                  state   <= S_HALT;
                end else begin
                  sp <= sp - SP1;
                  if (top_w.lo != 8'd0) begin
                    rem   <= top_w.lo;
                    uptr  <= top_w.hi + top_w.lo - 8'd1;
                    state <= S_UNWIND;
                  end
                end
              end
              TAG_FUN: begin
                if (fun_under) begin
                  fault_q <= 1'b1;
                  state   <= S_HALT;
                end else if (heap_over) begin
                  ovf_q <= 1'b1;
                  state <= S_HALT;
                end else if (hdr_w.hi == 8'd0) begin
                  sp <= sp - SPW'(top_w.lo);
                end else begin
                  base   <= 8'(hp);
                  root   <= hdr_w.lo;
                  arity  <= top_w.lo;
                  argtop <= sp - SP2;
                  dst    <= sp - SP1 - SPW'(top_w.lo);
                  rem    <= hdr_w.hi;
                  cptr   <= CAW'(top_w.hi) + CAW'(1);
                  state  <= S_FETCH;
                end
              end
              default: ;
            endcase
          end
        end
        S_FETCH: begin
          fbuf  <= c_row;
          cptr  <= cptr + CAW'(FETCH_W);
          bidx  <= '0;
          state <= S_COPY;
        end
        S_COPY: begin
          if (rw_bad) begin
            fault_q <= 1'b1;
            state   <= S_HALT;
          end else begin
            hp  <= hp + HPW'(1);
            rem <= rem - 8'd1;
            if (rem == 8'd1) begin
              sp    <= dst + SP1;
              state <= S_DISP;
            end else if (bidx == BIW'(FETCH_W - 1)) begin
              state <= S_FETCH;
            end else begin
              bidx <= bidx + BIW'(1);
            end
          end
        end
        S_UNWIND: begin
          sp   <= sp + SP1;
          uptr <= uptr - 8'd1;
          rem  <= rem - 8'd1;
          if (rem == 8'd1) state <= S_DISP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  tir_stack_mem #(.DEPTH(STK_DEPTH)) u_stack (
    .clk(clk),
    .wa_en(s_wa_en), .wa_addr(s_wa_addr), .wa_data(s_wa_data),
    .wb_en(s_wb_en), .wb_addr(s_wb_addr), .wb_data(s_wb_data),
    .ra_addr(s_ra_addr), .ra_data(s_ra_data),
    .rb_addr(s_rb_addr), .rb_data(s_rb_data),
    .rc_addr(dbg_addr), .rc_data(s_rc_data)
  );

  tir_heap_mem #(.DEPTH(HEAP_DEPTH)) u_heap (
    .clk(clk),
    .wr_en(h_wr_en), .wr_addr(HAW'(hp)), .wr_data(rw_out),
    .rd_addr(HAW'(uptr)), .rd_data(h_rd_data)
  );

  tir_code_mem #(.DEPTH(CODE_DEPTH), .FETCH_W(FETCH_W)) u_code (
    .clk(clk),
    .wr_en(code_wr_valid && code_wr_ready), .wr_addr(code_wr_addr),
    .wr_data(word_t'(code_wr_data)),
    .rd_addr(c_rd_addr), .rd_row(c_row)
  );

  tir_rewriter u_rw (
    .tmpl(fbuf[bidx]), .base(base), .arity(arity), .arg_val(s_ra_data),
    .out(rw_out), .arg_idx(rw_idx), .bad_arg(rw_bad)
  );
endmodule

// File: rtl/tir_core_chk.sv
module tir_core_chk #(
  parameter int STK_DEPTH = 32,
  parameter int SPW       = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           fault,
  input logic           heap_ovf,
  input logic           code_wr_ready,
  input logic [SPW-1:0] stack_depth
);
  // R1
  preload_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !code_wr_ready);

  // R2
  start_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !fault && !heap_ovf && stack_depth == SPW'(1)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (stack_depth == SPW'(1)));

  // R10
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !start) |=> fault);

  // R10
  halted_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault || heap_ovf || done) |-> !busy);

  // R11
  heap_full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (heap_ovf && !start) |=> heap_ovf);

  // R12
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_depth <= SPW'(STK_DEPTH));
endmodule

bind tir_core tir_core_chk #(.STK_DEPTH(STK_DEPTH), .SPW(SPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fault(fault), .heap_ovf(heap_ovf), .code_wr_ready(code_wr_ready),
  .stack_depth(stack_depth)
);

// File: tb/tir_core_tb.sv
module tir_core_tb;
  localparam int FW = 2;
  localparam logic [1:0] T_INT = 2'b00, T_ARG = 2'b01, T_APP = 2'b10, T_FUN = 2'b11;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [17:0] start_word = '0;
  logic        busy, done, fault, heap_ovf;
  logic        code_wr_valid = 1'b0, code_wr_ready;
  logic [7:0]  code_wr_addr = '0;
  logic [17:0] code_wr_data = '0;
  logic [4:0]  dbg_addr = '0;
  logic [17:0] dbg_data;
  logic [5:0]  stack_depth;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  tir_core u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_word(start_word),
    .busy(busy), .done(done), .fault(fault), .heap_ovf(heap_ovf),
    .code_wr_valid(code_wr_valid), .code_wr_ready(code_wr_ready),
    .code_wr_addr(code_wr_addr), .code_wr_data(code_wr_data),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .stack_depth(stack_depth)
  );

  function automatic logic [17:0] mk(logic [1:0] t, logic [7:0] h, logic [7:0] l);
    return {t, h, l};
  endfunction

  function automatic int lat_delta(int t_small, int t_big);
    return ((t_big + FW - 1) / FW - (t_small + FW - 1) / FW) + (t_big - t_small);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_stk(input string req, input int idx, input logic [17:0] exp);
    dbg_addr = 5'(idx);
    #1;
    chk(req, $sformatf("stack[%0d]", idx), 32'(dbg_data), 32'(exp));
  endtask

  task automatic code_wr(input logic [7:0] a, input logic [17:0] d);
    @(negedge clk);
    code_wr_valid = 1'b1;
    code_wr_addr  = a;
    code_wr_data  = d;
    @(negedge clk);
    code_wr_valid = 1'b0;
  endtask

  task automatic wait_halt(inout int cyc);
    while (busy && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run(input logic [17:0] w, output int cyc);
    @(negedge clk);
    start = 1'b1;
    start_word = w;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    wait_halt(cyc);
  endtask

  // main template at 0: spine [FUNC(16,2), x, y]
  task automatic load_main(input logic [17:0] xw, input logic [17:0] yw);
    code_wr(8'd0, mk(T_INT, 8'd3, 8'd3));
    code_wr(8'd1, mk(T_FUN, 8'd16, 8'd2));
    code_wr(8'd2, xw);
    code_wr(8'd3, yw);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main_seq
    int c1, c2, c3;
    logic [17:0] xw, yw;
    logic [17:0] exp_sp [16];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R2", "busy after reset", 32'(busy), 0);
    chk("R9", "done after reset", 32'(done), 0);
    chk("R10", "fault after reset", 32'(fault), 0);
    chk("R11", "heap_ovf after reset", 32'(heap_ovf), 0);
    chk("R12", "depth after reset", 32'(stack_depth), 0);
    chk("R1", "ready when idle", 32'(code_wr_ready), 1);

    // R9 / R13: short template [INT 42]
    code_wr(8'd32, mk(T_INT, 8'd1, 8'd1));
    code_wr(8'd33, mk(T_INT, 8'd0, 8'd42));
    run(mk(T_FUN, 8'd32, 8'd0), c1);
    chk("R9", "done short", 32'(done), 1);
    chk("R9", "depth short", 32'(stack_depth), 1);
    chk_stk("R9", 0, mk(T_INT, 8'd0, 8'd42));

    // R13: same result with four extra unused words
    code_wr(8'd40, mk(T_INT, 8'd5, 8'd1));
    code_wr(8'd41, mk(T_INT, 8'd0, 8'd42));
    for (int i = 0; i < 4; i++) code_wr(8'(42 + i), mk(T_INT, 8'd9, 8'(i)));
    run(mk(T_FUN, 8'd40, 8'd0), c2);
    chk("R13", "extra cycles for longer template", 32'(c2 - c1), 32'(lat_delta(1, 5)));
    chk("R9", "done long", 32'(done), 1);

    // R2 / R1: start during busy is ignored, ready low while busy
    @(negedge clk);
    start = 1'b1;
    start_word = mk(T_FUN, 8'd40, 8'd0);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R1", "ready low while busy", 32'(code_wr_ready), 0);
    start = 1'b1;
    start_word = mk(T_INT, 8'd0, 8'd99);
    @(negedge clk);
    start = 1'b0;
    c3 = 0;
    wait_halt(c3);
    chk("R2", "run unaffected by start while busy", 32'(done), 1);
    chk_stk("R2", 0, mk(T_INT, 8'd0, 8'd42));

    // R3: spine [INT 7, FUNC(200,15)] -> swap then underflow fault
    code_wr(8'd48, mk(T_INT, 8'd2, 8'd2));
    code_wr(8'd49, mk(T_INT, 8'd0, 8'd7));
    code_wr(8'd50, mk(T_FUN, 8'd200, 8'd15));
    run(mk(T_FUN, 8'd48, 8'd0), c3);
    chk("R3", "fault after swap", 32'(fault), 1);
    chk("R3", "depth after swap", 32'(stack_depth), 2);
    chk_stk("R3", 1, mk(T_FUN, 8'd200, 8'd15));
    chk_stk("R3", 0, mk(T_INT, 8'd0, 8'd7));

    // R10: empty stack after zero-length application
    run(mk(T_APP, 8'd0, 8'd0), c3);
    chk("R10", "fault on empty", 32'(fault), 1);
    chk("R10", "depth empty", 32'(stack_depth), 0);

    // R10: unwind past stack capacity
    run(mk(T_APP, 8'd0, 8'd40), c3);
    chk("R10", "fault on stack overflow", 32'(fault), 1);
    chk("R10", "depth kept on overflow", 32'(stack_depth), 1);
    chk_stk("R10", 0, mk(T_APP, 8'd0, 8'd40));

    // R10: function without enough arguments
    run(mk(T_FUN, 8'd0, 8'd1), c3);
    chk("R10", "fault on missing args", 32'(fault), 1);
    chk("R10", "depth on missing args", 32'(stack_depth), 1);

    // R7: argument index beyond arity
    load_main(mk(T_INT, 8'd0, 8'd1), mk(T_INT, 8'd0, 8'd2));
    code_wr(8'd16, mk(T_INT, 8'd1, 8'd1));
    code_wr(8'd17, mk(T_ARG, 8'd0, 8'd2));
    run(mk(T_FUN, 8'd0, 8'd0), c3);
    chk("R7", "fault on bad arg index", 32'(fault), 1);
    chk("R7", "depth on bad arg", 32'(stack_depth), 3);
    chk_stk("R7", 2, mk(T_FUN, 8'd16, 8'd2));

    // R11: heap exhaustion (3 used + 255 requested > 256)
    code_wr(8'd16, mk(T_INT, 8'd255, 8'd1));
    run(mk(T_FUN, 8'd0, 8'd0), c3);
    chk("R11", "heap_ovf", 32'(heap_ovf), 1);
    chk("R11", "no fault on heap full", 32'(fault), 0);
    chk("R11", "busy low on heap full", 32'(busy), 0);
    chk("R11", "depth on heap full", 32'(stack_depth), 3);

    // R2: flags cleared by the next start
    run(mk(T_FUN, 8'd32, 8'd0), c3);
    chk("R2", "heap_ovf cleared", 32'(heap_ovf), 0);
    chk("R2", "done after restart", 32'(done), 1);

    // R4 R5 R6 R7 R8 R12: random templates observed after a forced stop
    for (int it = 0; it < 24; it++) begin
      int k, extra;
      xw = mk(T_INT, 8'($urandom), 8'($urandom));
      yw = mk(T_INT, 8'($urandom), 8'($urandom));
      load_main(xw, yw);
      k = 2 + int'($urandom % 7);
      extra = int'($urandom % 4);
      code_wr(8'd16, mk(T_INT, 8'(k + extra), 8'(k)));
      exp_sp[0] = mk(T_FUN, 8'd200, 8'd15);
      code_wr(8'd17, exp_sp[0]);
      for (int m = 1; m < k; m++) begin
        int kind;
        logic [7:0] h, l;
        kind = int'($urandom % 4);
        h = 8'($urandom);
        l = 8'($urandom);
        case (kind)
          0: begin code_wr(8'(17 + m), mk(T_INT, h, l)); exp_sp[m] = mk(T_INT, h, l); end
          1: begin
            code_wr(8'(17 + m), mk(T_ARG, h, 8'(l % 2)));
            exp_sp[m] = (l % 2 == 0) ? xw : yw;
          end
          2: begin code_wr(8'(17 + m), mk(T_APP, h, l)); exp_sp[m] = mk(T_APP, h + 8'd3, l); end
          default: begin code_wr(8'(17 + m), mk(T_FUN, h, l)); exp_sp[m] = mk(T_FUN, h, l); end
        endcase
      end
      for (int e = 0; e < extra; e++) code_wr(8'(17 + k + e), mk(T_INT, 8'd0, 8'(e)));
      run(mk(T_FUN, 8'd0, 8'd0), c3);
      chk("R10", "stop fault in random run", 32'(fault), 1);
      chk("R8", "depth after instantiate and unwind", 32'(stack_depth), 32'(k));
      for (int m = 0; m < k; m++) chk_stk("R6", k - 1 - m, exp_sp[m]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule